// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

A register-mapped timer with `NCH` independent down-counting channels of `CW` bits each. Software programs a reload value per channel and turns the channel on. The channel then counts down on every clock. When it passes zero it reloads, raises a sticky event flag and, if allowed, an interrupt line. A channel may be linked to the channel below it so that it only steps when that neighbour expires. Two linked channels of 32 bits each then act as one 64-bit counter.

Software reaches the block through a plain synchronous port: address, write data, write strobe, read strobe and registered read data. A module-level register holds a global stop bit, and the block comes out of reset stopped. Each channel owns a 16-byte bank with four words: reload value, live count, control and event flag. One interrupt line per channel is brought out, together with their OR.

Top module: `multi_chan_timer`

## Requirements
- R1: After reset the module register (offset 0x000) reads 0x2 (global stop set), every channel register reads 0, and all interrupt outputs are low.
- R2: Register map: module register at 0x000, with bit 1 as the global stop bit. Channel n's bank is at 0x100 + 0x10*n, holding the reload value at +0x0, the live count at +0x4, control at +0x8 and the flag at +0xC. In the control word, bit 0 is run enable, bit 1 is interrupt enable and bit 2 is link-to-previous. Read data appears on the clock edge that samples the read strobe. Unmapped or unaligned addresses read as 0.
- R3: On the edge after the run-enable bit goes from 0 to 1, the count is loaded from the reload register.
- R4: The count holds its value while the channel's run enable is 0, and also while the global stop bit is 1.
- R5: A running channel decrements once per step. A step that finds the count at zero reloads it, so a reload value of N gives one expiry every N+1 steps.
- R6: Writing the reload register does not change the running count. The new value is first used at the next reload, or on a disable followed by an enable.
- R7: An expiry sets the channel flag on the same edge that reloads the count. The flag stays set until it is cleared. If a clear and an expiry meet on the same edge, the flag is left set.
- R8: Writing the flag word with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R9: A channel n > 0 with link-to-previous set steps only on cycles where channel n-1 expires. Channel 0 steps on every clock.
- R10: `irq_ch[n]` is high exactly when channel n's flag and interrupt enable are both 1. `irq_any` is the OR of all `irq_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | CW | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | CW | Registered read data |
| irq_ch | output | NCH | Per-channel interrupt |
| irq_any | output | 1 | OR of all channel interrupts |

## Verification
The bench writes a new reload value while a count is in flight and reads the live count. A design that restarts on that write returns the new value where the old count should still be running down. The bench issues a flag clear on the exact edge of an expiry; if the clear wins, the event is lost and the flag reads 0. It toggles enable off and on, which must restart from the new reload value and not resume the held count. It also steps a linked channel only from its neighbour's expiries, which a design that counts on the raw clock would run ahead of.

// File: rtl/mct_pkg.sv
package mct_pkg;

  // control word fields, bit 0 = run, bit 1 = irq enable, bit 2 = link
  typedef struct packed {
    logic link;
    logic ie;
    logic run;
  } ctl_t;

  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTL    = 2'd2,
    SEL_FLAG   = 2'd3
  } wsel_e;

  localparam int unsigned BANK_PAGE   = 1;  // addr[AW-1:8] value of channel banks
  localparam int unsigned STOP_BIT    = 1;  // module register stop bit

endpackage

// File: rtl/mct_channel.sv
module mct_channel
  import mct_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_ok,
  input  logic          step_in,
  input  logic          ld_we,
  input  logic [CW-1:0] ld_wdata,
  input  logic          ctl_we,
  input  ctl_t          ctl_wdata,
  input  logic          flg_clr,
  output logic [CW-1:0] ld_q,
  output logic [CW-1:0] cnt_q,
  output ctl_t          ctl_q,
  output logic          flag_q,
  output logic          expire,
  output logic          irq
);

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic [CW-1:0] r);
    return (c == '0) ? r : c - CW'(1);
  endfunction

  logic en_q;
  logic start;
  logic live;

  assign start  = ctl_q.run & ~en_q;
  assign live   = ctl_q.run & en_q & run_ok & step_in;
  assign expire = live & (cnt_q == '0);
  assign irq    = flag_q & ctl_q.ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_q   <= '0;
      ctl_q  <= '0;
      en_q   <= 1'b0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ld_we)  ld_q  <= ld_wdata;
      if (ctl_we) ctl_q <= ctl_wdata;
      en_q <= ctl_q.run;
      if (start)     cnt_q <= ld_q;
      else if (live) cnt_q <= next_count(cnt_q, ld_q);
      if (expire)       flag_q <= 1'b1;
      else if (flg_clr) flag_q <= 1'b0;
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == $past(ld_q));  // R3
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.run |=> $stable(cnt_q));  // R4
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_ok && !start) |=> $stable(cnt_q));  // R4
  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt_q == $past(ld_q));  // R5
  AST_FLAG_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);  // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flg_clr) |=> flag_q);  // R7

endmodule

// File: rtl/mct_decode.sv
module mct_decode
  import mct_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  input  logic                    we,
  input  logic                    re,
  input  logic                    stop_q,
  input  logic [NCH-1:0][CW-1:0]  ld_a,
  input  logic [NCH-1:0][CW-1:0]  cnt_a,
  input  ctl_t [NCH-1:0]          ctl_a,
  input  logic [NCH-1:0]          flag_a,
  output logic                    mod_we,
  output logic [NCH-1:0]          ld_we,
  output logic [NCH-1:0]          ctl_we,
  output logic [NCH-1:0]          flg_clr,
  output logic [CW-1:0]           rdata
);

  localparam int unsigned PW = AW - 8;

  logic       aligned;
  logic       mod_hit;
  logic       page_hit;
  logic [3:0] idx;
  wsel_e      sel;
  logic [CW-1:0] rmux;

  assign aligned  = (addr[1:0] == 2'b00);
  assign mod_hit  = aligned && (addr[AW-1:2] == '0);
  assign page_hit = aligned && (addr[AW-1:8] == PW'(BANK_PAGE));
  assign idx      = addr[7:4];
  assign sel      = wsel_e'(addr[3:2]);
  assign mod_we   = we && mod_hit;

  always_comb begin
    ld_we   = '0;
    ctl_we  = '0;
    flg_clr = '0;
    rmux    = '0;
    if (mod_hit) rmux[STOP_BIT] = stop_q;
    for (int i = 0; i < int'(NCH); i++) begin
      if (page_hit && idx == 4'(i)) begin
        ld_we[i]   = we && (sel == SEL_RELOAD);
        ctl_we[i]  = we && (sel == SEL_CTL);
        flg_clr[i] = we && (sel == SEL_FLAG) && wdata[0];
        case (sel)
          SEL_RELOAD: rmux = ld_a[i];
          SEL_COUNT:  rmux = cnt_a[i];
          SEL_CTL:    rmux = {{(CW-3){1'b0}}, ctl_a[i]};
          default:    rmux = {{(CW-1){1'b0}}, flag_a[i]};
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rmux;
  end

endmodule

// File: rtl/multi_chan_timer.sv
module multi_chan_timer
  import mct_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  input  logic           bus_we,
  input  logic           bus_re,
  output logic [CW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq_ch,
  output logic           irq_any
);

  logic                   stop_q;
  logic                   mod_we;
  logic [NCH-1:0]         ld_we, ctl_we, flg_clr;
  logic [NCH-1:0][CW-1:0] ld_a, cnt_a;
  ctl_t [NCH-1:0]         ctl_a;
  logic [NCH-1:0]         flag_a, expire_a, step_a;

  always_ff @(posedge clk) begin
    if (!rst_n)      stop_q <= 1'b1;
    else if (mod_we) stop_q <= bus_wdata[STOP_BIT];
  end

  mct_decode #(.NCH(NCH), .CW(CW), .AW(AW)) u_decode (
    .clk, .rst_n,
    .addr(bus_addr), .wdata(bus_wdata), .we(bus_we), .re(bus_re),
    .stop_q, .ld_a, .cnt_a, .ctl_a, .flag_a,
    .mod_we, .ld_we, .ctl_we, .flg_clr, .rdata(bus_rdata)
  );

  for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
    if (g == 0) begin : g_head
      assign step_a[g] = 1'b1;
    end else begin : g_link
      assign step_a[g] = ctl_a[g].link ? expire_a[g-1] : 1'b1;
    end
    mct_channel #(.CW(CW)) u_ch (
      .clk, .rst_n,
      .run_ok(~stop_q), .step_in(step_a[g]),
      .ld_we(ld_we[g]), .ld_wdata(bus_wdata),
      .ctl_we(ctl_we[g]), .ctl_wdata(ctl_t'(bus_wdata[2:0])),
      .flg_clr(flg_clr[g]),
      .ld_q(ld_a[g]), .cnt_q(cnt_a[g]), .ctl_q(ctl_a[g]),
      .flag_q(flag_a[g]), .expire(expire_a[g]), .irq(irq_ch[g])
    );
  end

  assign irq_any = |irq_ch;

  AST_STOP_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> expire_a == '0);  // R4

endmodule

// File: tb/multi_chan_timer_bench.sv
module multi_chan_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 32;
  localparam int AW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [CW-1:0] bus_rdata;
  logic [NCH-1:0] irq_ch;
  logic irq_any;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [CW-1:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multi_chan_timer #(.NCH(NCH), .CW(CW), .AW(AW)) u_multi_chan_timer (
    .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_re,
    .bus_rdata, .irq_ch, .irq_any
  );

  function automatic logic [AW-1:0] bank(input int ch, input int off);
    return AW'(256 + 16*ch + off);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [CW-1:0] act,
                       input logic [CW-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard when read data has arrived
  always @(posedge clk) rd_seen <= bus_re;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [CW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(bus_rdata === e, t, bus_rdata, e);
    end
  end

  task automatic op_wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic op_rd(input logic [AW-1:0] a, input logic [CW-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    op_rd(12'h000, 32'h2, "R1 module reg");
    op_rd(bank(2, 4), 32'h0, "R1 count");
    check(irq_any === 1'b0, "R1 irq_any", 32'(irq_any), 32'h0);

    // R4 global stop: enabled channel loads but does not step
    op_wr(bank(2, 0), 32'd7);
    op_wr(bank(2, 8), 32'h1);
    idle(1);
    op_rd(bank(2, 4), 32'd7, "R3 load on enable");
    idle(3);
    op_rd(bank(2, 4), 32'd7, "R4 frozen by stop");
    op_wr(12'h000, 32'h0);
    op_rd(bank(2, 4), 32'd7, "R4 stop edge");
    idle(2);
    op_rd(bank(2, 4), 32'd4, "R5 counting");

    // channel 3: reload 4, period 5, irq enabled
    op_wr(bank(3, 0), 32'd4);
    op_wr(bank(3, 8), 32'h3);            // E0
    idle(4);
    op_rd(bank(3, 12), 32'd0, "R5 flag before expiry");   // E5
    check(irq_ch[3] === 1'b0, "R10 irq before expiry", 32'(irq_ch[3]), 32'h0);
    idle(1);                              // E6 expiry
    check(irq_ch[3] === 1'b1, "R10 irq on flag", 32'(irq_ch[3]), 32'h1);
    check(irq_any === 1'b1, "R10 irq_any", 32'(irq_any), 32'h1);
    op_rd(bank(3, 4), 32'd4, "R5 reload");                // E7
    op_rd(bank(3, 12), 32'd1, "R7 flag set");             // E8
    op_wr(bank(3, 12), 32'h0);                            // E9
    op_rd(bank(3, 12), 32'd1, "R8 write 0 ignored");      // E10
    op_wr(bank(3, 12), 32'h1);                            // E11 clear meets expiry
    op_rd(bank(3, 12), 32'd1, "R7 expiry beats clear");   // E12
    op_wr(bank(3, 12), 32'h1);                            // E13
    op_rd(bank(3, 12), 32'd0, "R8 write 1 clears");       // E14
    check(irq_ch[3] === 1'b0, "R10 irq after clear", 32'(irq_ch[3]), 32'h0);

    // R6 reload write does not restart
    op_wr(bank(3, 0), 32'd9);                             // E15
    op_rd(bank(3, 4), 32'd0, "R6 no restart on write");   // E16
    op_rd(bank(3, 4), 32'd9, "R6 new value at reload");   // E17
    op_wr(bank(3, 0), 32'd20);                            // E18
    op_rd(bank(3, 4), 32'd7, "R6 running on");            // E19
    op_wr(bank(3, 8), 32'h2);                             // E20 disable
    op_wr(bank(3, 8), 32'h3);                             // E21 enable
    op_rd(bank(3, 4), 32'd5, "R4 held while disabled");   // E22
    op_rd(bank(3, 4), 32'd20, "R6 restart from new");     // E23

    // R9 link: channel 1 steps on channel 0 expiries
    op_wr(bank(1, 0), 32'd1);
    op_wr(bank(1, 8), 32'h5);
    idle(3);
    op_rd(bank(1, 4), 32'd1, "R9 no step without neighbour");
    op_wr(bank(0, 0), 32'd2);
    op_wr(bank(0, 8), 32'h1);                             // G0
    idle(5);
    op_rd(bank(1, 4), 32'd0, "R9 one step per expiry");   // G6
    op_rd(bank(1, 12), 32'd0, "R9 flag not yet");         // G7
    op_rd(bank(1, 12), 32'd1, "R9 linked expiry");        // G8
    check(irq_ch[1] === 1'b0, "R10 irq gated by ie", 32'(irq_ch[1]), 32'h0);
    op_rd(bank(1, 4), 32'd1, "R9 linked reload");         // G9

    // R2 map readback
    op_rd(bank(1, 8), 32'h5, "R2 control fields");
    op_rd(12'h000, 32'h0, "R2 module reg");
    op_rd(12'h0F0, 32'h0, "R2 unmapped");
    op_rd(bank(3, 2), 32'h0, "R2 unaligned");
    idle(2);
    finish_up();
  end
endmodule